// File: doc/BRIEF.md
# Dual-Input Cascadable Up/Down Counter

This block is a binary counter with two separate step inputs, one that counts up and one that counts down, in place of a single clock and a direction bit. A rising edge on one step input, while the other step input rests high, moves the count by one in that direction. The count wraps at both ends. An active-low preset copies a data word into the count. An active-high clear forces the count to zero and overrides the preset and both step inputs.

The step inputs, preset, clear and data word are asynchronous to the block. Each passes through a flop synchronizer on one free-running system clock, and step edges are found on the synchronized levels. The block has two active-low cascade flags. The borrow flag is low while the count is zero and the down input is low. The carry flag is low while the count is at its maximum and the up input is low. Wiring the flags of one instance to the step inputs of the next chains instances into a wider counter with no extra logic.

With default parameters the count is 4 bits wide and the synchronizers are two flops deep. A change on any input therefore reaches the count register on the third rising clock edge after it is applied.

Top module: `dual_step_counter`

## Requirements
- R1: A rising edge on `up_step` while `dn_step` is high increments `count` by one, and the maximum value wraps to 0. The new value appears after the third rising clock edge that follows the input change.
- R2: A rising edge on `dn_step` while `up_step` is high decrements `count` by one, and 0 wraps to the maximum value. The latency is the same as in R1.
- R3: A rising edge on one step input while the other step input is low leaves `count` unchanged.
- R4: If both step inputs rise in the same synchronized clock cycle, `count` is unchanged.
- R5: While `load_n` is low, `count` follows `pre_val` on every clock, with the same three-edge latency, and step edges have no effect.
- R6: While `clear` is high, `count` is 0, and neither `load_n` nor the step inputs change it.
- R7: `borrow_n` is 0 exactly when `count` is 0 and the synchronized `dn_step` is low. Otherwise it is 1.
- R8: `carry_n` is 0 exactly when `count` is at its maximum (all ones) and the synchronized `up_step` is low. Otherwise it is 1.
- R9: Two instances form an 8-bit counter when the first one's `carry_n` drives the second one's `up_step` and its `borrow_n` drives the second one's `dn_step`. The pair wraps correctly between 0x0F and 0x10 and between 0xFF and 0x00, in both directions.
- R10: After reset, `count` is 0, both flags are 1, and both step inputs are taken to be high, so the first release of the step inputs produces no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples every other input |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_step | input | 1 | Count-up step; acts on its rising edge |
| dn_step | input | 1 | Count-down step; acts on its rising edge |
| load_n | input | 1 | Active-low preset enable |
| clear | input | 1 | Active-high clear; dominates all other inputs |
| pre_val | input | WIDTH | Preset data word |
| count | output | WIDTH | Counter value |
| borrow_n | output | 1 | Active-low borrow flag, for cascading downward |
| carry_n | output | 1 | Active-low carry flag, for cascading upward |

## Verification
The assertions work on the synchronized inputs, so they assume only that each input level lasts long enough for the synchronizer to capture it. The clocked properties assume that `rst_n` starts every run. The stimulus holds every step level, low or high, for several clock cycles. Both step inputs rest high between operations. When a test has to drive one step input low while the other is low, it releases the two together so that the release counts as a simultaneous rise and not as a stray step. Preset and clear are held for at least four cycles and are released only while both step inputs are high.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

   // Action decoded from the synchronized step inputs for one clock cycle.
   typedef enum logic [1:0] {
      ST_HOLD = 2'd0,
      ST_INC  = 2'd1,
      ST_DEC  = 2'd2
   } step_e;

   // True when every bit of the vector is zero.
   function automatic logic all_clear(input logic [31:0] v, input int unsigned w);
      logic z;
      z = 1'b1;
      for (int i = 0; i < 32; i++) begin
         if (i < w && v[i]) z = 1'b0;
      end
      return z;
   endfunction

   // True when every one of the low w bits is set.
   function automatic logic all_set(input logic [31:0] v, input int unsigned w);
      logic s;
      s = 1'b1;
      for (int i = 0; i < 32; i++) begin
         if (i < w && !v[i]) s = 1'b0;
      end
      return s;
   endfunction

endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
   parameter int unsigned W       = 8,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   localparam int unsigned LAST = STAGES - 1;

   logic [W-1:0] chain [STAGES];

   generate
      if (STAGES < 1) begin : g_bad_depth
         $error("dsc_sync: STAGES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[LAST];

endmodule

// File: rtl/dsc_edge.sv
module dsc_edge
   import dsc_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  up_s,
   input  logic  dn_s,
   output step_e step
);

   logic up_q;
   logic dn_q;
   logic up_rise;
   logic dn_rise;

   // Previous levels start high, so the first release after reset is no edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_q <= 1'b1;
         dn_q <= 1'b1;
      end else begin
         up_q <= up_s;
         dn_q <= dn_s;
      end
   end

   assign up_rise = up_s & ~up_q;
   assign dn_rise = dn_s & ~dn_q;

   always_comb begin
      step = ST_HOLD;
      if (up_rise && dn_rise)  step = ST_HOLD;
      else if (up_rise && dn_s) step = ST_INC;
      else if (dn_rise && up_s) step = ST_DEC;
   end

   // R3: an increment is issued only while the down line rests high
   p_inc_other_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step == ST_INC) |-> (dn_s && $past(dn_s)));

   // R3: a decrement is issued only while the up line rests high
   p_dec_other_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step == ST_DEC) |-> (up_s && $past(up_s)));

endmodule

// File: rtl/dsc_core.sv
module dsc_core
   import dsc_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_s,
   input  logic             load_n_s,
   input  logic [WIDTH-1:0] din_s,
   input  step_e            step,
   output logic [WIDTH-1:0] cnt
);

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr_s) begin
         cnt <= '0;
      end else if (!load_n_s) begin
         cnt <= din_s;
      end else begin
         unique case (step)
            ST_INC:  cnt <= cnt + ONE;
            ST_DEC:  cnt <= cnt - ONE;
            default: cnt <= cnt;
         endcase
      end
   end

   // R6: clear empties the register whatever else is asserted
   p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_s |=> (cnt == '0));

   // R5: while preset is active the register tracks the data word
   p_load_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_s && !load_n_s) |=> (cnt == $past(din_s)));

   // R4: with no accepted step the value is kept
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_s && load_n_s && step == ST_HOLD) |=> $stable(cnt));

   // R1: an accepted up step adds exactly one, modulo the width
   p_inc_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_s && load_n_s && step == ST_INC) |=> (cnt == WIDTH'($past(cnt) + ONE)));

   // R2: an accepted down step removes exactly one, modulo the width
   p_dec_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_s && load_n_s && step == ST_DEC) |=> (cnt == WIDTH'($past(cnt) - ONE)));

endmodule

// File: rtl/dsc_flags.sv
module dsc_flags
   import dsc_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] cnt,
   input  logic             up_s,
   input  logic             dn_s,
   output logic             borrow_n,
   output logic             carry_n
);

   logic at_floor;
   logic at_ceiling;

   assign at_floor   = all_clear(32'(cnt), WIDTH);
   assign at_ceiling = all_set(32'(cnt), WIDTH);

   assign borrow_n = ~(at_floor & ~dn_s);
   assign carry_n  = ~(at_ceiling & ~up_s);

   // R7: a low borrow flag implies an empty count and a low down line
   p_borrow_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !borrow_n |-> (cnt == '0 && !dn_s));

   // R8: a low carry flag implies a full count and a low up line
   p_carry_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !carry_n |-> ((&cnt) && !up_s));

   // R7 R8: both flags can be low together only at a width of zero bits, never here
   p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(!borrow_n && !carry_n && cnt != '0 && !(&cnt)));

endmodule

// File: rtl/dual_step_counter.sv
module dual_step_counter
   import dsc_pkg::*;
#(
   parameter int unsigned WIDTH       = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_step,
   input  logic             dn_step,
   input  logic             load_n,
   input  logic             clear,
   input  logic [WIDTH-1:0] pre_val,
   output logic [WIDTH-1:0] count,
   output logic             borrow_n,
   output logic             carry_n
);

   localparam int unsigned  IW       = WIDTH + 4;
   localparam logic [IW-1:0] IDLE_IN = {1'b0, 1'b1, 1'b1, 1'b1, {WIDTH{1'b0}}};

   generate
      if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
         $error("dual_step_counter: WIDTH must lie in 1..32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("dual_step_counter: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [IW-1:0]    raw_in;
   logic [IW-1:0]    syn_in;
   logic             clr_s;
   logic             load_n_s;
   logic             dn_s;
   logic             up_s;
   logic [WIDTH-1:0] din_s;
   step_e            step;

   assign raw_in = {clear, load_n, dn_step, up_step, pre_val};

   dsc_sync #(
      .W       (IW),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (IDLE_IN)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn_in)
   );

   assign {clr_s, load_n_s, dn_s, up_s, din_s} = syn_in;

   dsc_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .up_s  (up_s),
      .dn_s  (dn_s),
      .step  (step)
   );

   dsc_core #(
      .WIDTH (WIDTH)
   ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_s    (clr_s),
      .load_n_s (load_n_s),
      .din_s    (din_s),
      .step     (step),
      .cnt      (count)
   );

   dsc_flags #(
      .WIDTH (WIDTH)
   ) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt      (count),
      .up_s     (up_s),
      .dn_s     (dn_s),
      .borrow_n (borrow_n),
      .carry_n  (carry_n)
   );

   // R4: two edges arriving in one cycle never move the count
   p_dual_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_s && load_n_s && up_s && dn_s && !$past(up_s) && !$past(dn_s))
      |=> $stable(count));

endmodule

// File: tb/dual_step_counter_test.sv
module dual_step_counter_test;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n;
   logic       s_up, s_dn, s_ld, s_cl;
   logic [3:0] s_d;
   logic [3:0] s_q;
   logic       s_b, s_c;

   logic       c_up, c_dn, c_ld, c_cl;
   logic [7:0] c_d;
   logic [3:0] lo_q, hi_q;
   logic       lo_b, lo_c, hi_b, hi_c;

   int  total = 0;
   int  bad   = 0;
   bit  done  = 0;
   logic [3:0] m;
   logic [7:0] cm;

   dual_step_counter uut (
      .clk(clk), .rst_n(rst_n), .up_step(s_up), .dn_step(s_dn),
      .load_n(s_ld), .clear(s_cl), .pre_val(s_d),
      .count(s_q), .borrow_n(s_b), .carry_n(s_c));

   dual_step_counter cas_lo (
      .clk(clk), .rst_n(rst_n), .up_step(c_up), .dn_step(c_dn),
      .load_n(c_ld), .clear(c_cl), .pre_val(c_d[3:0]),
      .count(lo_q), .borrow_n(lo_b), .carry_n(lo_c));

   dual_step_counter cas_hi (
      .clk(clk), .rst_n(rst_n), .up_step(lo_c), .dn_step(lo_b),
      .load_n(c_ld), .clear(c_cl), .pre_val(c_d[7:4]),
      .count(hi_q), .borrow_n(hi_b), .carry_n(hi_c));

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drive(input bit cas, input logic u, input logic d);
      if (cas) begin c_up = u; c_dn = d; end
      else     begin s_up = u; s_dn = d; end
   endtask

   // kind: 0 up, 1 down, 2 both together, 3 up while down held low
   task automatic pulse(input bit cas, input int kind, output logic fb, output logic fc);
      case (kind)
         0: drive(cas, 1'b0, 1'b1);
         1: drive(cas, 1'b1, 1'b0);
         default: drive(cas, 1'b0, 1'b0);
      endcase
      ticks(3);
      fb = cas ? lo_b : s_b;
      fc = cas ? lo_c : s_c;
      case (kind)
         0, 1, 2: drive(cas, 1'b1, 1'b1);
         default: begin
            drive(cas, 1'b1, 1'b0);
            ticks(8);
            drive(cas, 1'b0, 1'b0);
            ticks(3);
            drive(cas, 1'b1, 1'b1);
         end
      endcase
      ticks(8);
   endtask

   function automatic logic [3:0] nxt4(input logic [3:0] v, input int kind);
      if (kind == 0) return v + 4'd1;
      if (kind == 1) return v - 4'd1;
      return v;
   endfunction

   function automatic logic [7:0] nxt8(input logic [7:0] v, input int kind);
      if (kind == 0) return v + 8'd1;
      if (kind == 1) return v - 8'd1;
      return v;
   endfunction

   task automatic do_op(input int kind);
      logic fb, fc;
      logic eb, ec;
      eb = (m == 4'd0  && kind != 0) ? 1'b0 : 1'b1;
      ec = (m == 4'd15 && kind != 1) ? 1'b0 : 1'b1;
      pulse(1'b0, kind, fb, fc);
      m = nxt4(m, kind);
      chk("R7 borrow flag during low phase", int'(fb), int'(eb));
      chk("R8 carry flag during low phase", int'(fc), int'(ec));
      case (kind)
         0: chk("R1 count after up step", int'(s_q), int'(m));
         1: chk("R2 count after down step", int'(s_q), int'(m));
         2: chk("R4 count after simultaneous rise", int'(s_q), int'(m));
         default: chk("R3 count after step with other line low", int'(s_q), int'(m));
      endcase
   endtask

   task automatic do_load(input logic [3:0] v);
      s_ld = 1'b0; s_d = v;
      ticks(4);
      m = v;
      chk("R5 count follows preset", int'(s_q), int'(m));
      s_ld = 1'b1;
      ticks(3);
   endtask

   task automatic cas_load(input logic [7:0] v);
      c_ld = 1'b0; c_d = v;
      ticks(4);
      c_ld = 1'b1;
      ticks(4);
      cm = v;
      chk("R9 cascade preset", int'({hi_q, lo_q}), int'(cm));
   endtask

   task automatic cas_op(input int kind);
      logic fb, fc;
      pulse(1'b1, kind, fb, fc);
      cm = nxt8(cm, kind);
      chk("R9 cascade count", int'({hi_q, lo_q}), int'(cm));
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R9 watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic fb, fc;
      void'($urandom(32'd20240611));
      rst_n = 1'b0;
      s_up = 1'b1; s_dn = 1'b1; s_ld = 1'b1; s_cl = 1'b0; s_d = 4'd0;
      c_up = 1'b1; c_dn = 1'b1; c_ld = 1'b1; c_cl = 1'b0; c_d = 8'd0;
      ticks(3);
      rst_n = 1'b1;
      ticks(4);
      m = 4'd0;
      chk("R10 reset count", int'(s_q), 0);
      chk("R10 reset borrow", int'(s_b), 1);
      chk("R10 reset carry", int'(s_c), 1);

      // first release of a step line after reset must not be a step
      pulse(1'b0, 0, fb, fc);
      m = 4'd1;
      chk("R10 first pulse after reset counts once", int'(s_q), 1);

      s_cl = 1'b1;
      ticks(4);
      chk("R6 clear to zero", int'(s_q), 0);
      s_cl = 1'b0;
      ticks(3);
      m = 4'd0;

      // preset 13, five up, five down
      do_load(4'd13);
      for (int i = 0; i < 5; i++) do_op(0);
      chk("R1 wrapped up to 2", int'(s_q), 2);
      for (int i = 0; i < 5; i++) do_op(1);
      chk("R2 wrapped down to 13", int'(s_q), 13);

      do_op(2);
      do_op(3);
      do_load(4'd0);
      do_op(3);
      do_op(2);
      do_load(4'd15);
      do_op(3);
      do_op(0);
      chk("R1 max wraps to zero", int'(s_q), 0);
      do_op(1);
      chk("R2 zero wraps to max", int'(s_q), 15);

      // preset active: tracks data, ignores steps
      s_ld = 1'b0; s_d = 4'd9;
      ticks(4);
      chk("R5 preset tracks 9", int'(s_q), 9);
      s_d = 4'd4;
      ticks(4);
      chk("R5 preset tracks 4", int'(s_q), 4);
      pulse(1'b0, 0, fb, fc);
      chk("R5 step ignored during preset", int'(s_q), 4);
      s_ld = 1'b1;
      ticks(3);
      m = 4'd4;

      // clear dominates preset and steps
      s_cl = 1'b1; s_ld = 1'b0; s_d = 4'd7;
      ticks(4);
      chk("R6 clear beats preset", int'(s_q), 0);
      pulse(1'b0, 1, fb, fc);
      chk("R6 clear beats step", int'(s_q), 0);
      s_ld = 1'b1; s_cl = 1'b0;
      ticks(3);
      m = 4'd0;

      for (int n = 0; n < 250; n++) begin
         int r;
         r = int'($urandom % 7);
         if (r < 4) do_op(r);
         else if (r == 4) do_load(4'($urandom));
         else if (r == 5) begin
            s_cl = 1'b1;
            ticks(4);
            chk("R6 random clear", int'(s_q), 0);
            s_cl = 1'b0;
            ticks(3);
            m = 4'd0;
         end else begin
            ticks(5);
            chk("R7 idle borrow high", int'(s_b), 1);
            chk("R8 idle carry high", int'(s_c), 1);
            chk("R4 idle count stable", int'(s_q), int'(m));
         end
      end

      // cascaded pair
      cas_load(8'h0F); cas_op(0);
      chk("R9 0x0F to 0x10", int'({hi_q, lo_q}), 8'h10);
      cas_op(1);
      chk("R9 0x10 to 0x0F", int'({hi_q, lo_q}), 8'h0F);
      cas_load(8'hFF); cas_op(0);
      chk("R9 0xFF to 0x00", int'({hi_q, lo_q}), 8'h00);
      cas_op(1);
      chk("R9 0x00 to 0xFF", int'({hi_q, lo_q}), 8'hFF);
      cas_load(8'($urandom));
      for (int n = 0; n < 150; n++) cas_op(int'($urandom % 2));

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule